// File: doc/BRIEF.md
# Activation Gather Load Generator

This block turns one packet of 96 activation byte addresses into the shortest in-order series of SRAM load requests that can serve it. The packet is cut into twelve fixed slices of eight consecutive elements. Every slice is served by exactly one load, and each load reads a window of 256 contiguous bytes starting at its base address. Neighbouring slices share a load whenever all of their addresses fit in one window. Besides the loads, the block publishes a table with, for every element, the load that carries it and the byte offset of the element inside that load's window. A downstream gather stage uses this table to pick the packet's bytes out of the returned data.

A packet can be flagged as a weight packet. Weight data is already stored in execution order, so such a packet needs only one request for 96 consecutive bytes, starting at the address given for element 0. The other addresses are ignored. Loads leave the block one per cycle under a valid/ready handshake. A new packet is accepted only after the last load of the previous one has been taken.

Top module: `agl_gather_ldgen`

## Requirements
- R1: Slice s holds elements 8s to 8s+7. If any slice of an activation packet has a highest minus lowest address of 256 or more, the packet issues no loads. Bit s of `err_slices_o` is then set for every such slice, and the block returns to idle. A span of exactly 255 is legal.
- R2: Slices are grouped in ascending slice order. A new load starts at slice s exactly when adding slice s to the open group would make the group's span (max minus min over all its elements) 256 or more. The load count therefore equals this greedy count and lies between 1 and 12.
- R3: Each load carries `ld_base_o` equal to the minimum element address of its group, and `ld_slices_o` with bit s set for each slice it serves. `ld_idx_o` counts 0, 1, 2 and so on across the packet's loads, and `ld_last_o` is high only on the final load.
- R4: In the table, `elem_off_o[8i+7:8i]` holds the address of element i minus the base of its load, and `elem_ld_o[4i+3:4i]` holds that load's index. Both are valid from the first load of the packet until the next packet is accepted.
- R5: A weight packet (`pkt_weight_i`=1) issues one load with `ld_weight_o`=1. Its base is element 0's address, all twelve slice bits are set, the offset of element i is i, and every load index is 0. The other addresses and the span rule are ignored.
- R6: `pkt_ready_o` is high only when no packet is in progress. If a packet is accepted at clock edge N, the first load's `ld_valid_o` (or, for a rejected packet, `err_slices_o`) appears after edge N+1.
- R7: While `ld_valid_o` is high and `ld_ready_i` is low, the load stays valid and its fields hold. Exactly one load advances per handshake.
- R8: After reset, `pkt_ready_o`=1, `ld_valid_o`=0 and `err_slices_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pkt_valid_i | input | 1 | Packet offered |
| pkt_ready_o | output | 1 | Block idle, packet can be taken |
| pkt_weight_i | input | 1 | Packet is a weight packet |
| pkt_addr_i | input | 1920 | 96 byte addresses of 20 bits, element i at bits [20i+19:20i] |
| ld_valid_o | output | 1 | Load request valid |
| ld_ready_i | input | 1 | Load request taken |
| ld_base_o | output | 20 | Base byte address of the 256-byte window |
| ld_slices_o | output | 12 | Slices served by this load |
| ld_idx_o | output | 4 | Index of this load within the packet |
| ld_last_o | output | 1 | Final load of the packet |
| ld_weight_o | output | 1 | Load belongs to a weight packet |
| elem_off_o | output | 768 | Per-element byte offset in its load window |
| elem_ld_o | output | 384 | Per-element load index |
| err_slices_o | output | 12 | Slices that broke the span rule in the last packet |

## Verification
A packet accepted at edge N is planned at edge N+1. Its first load, its offset table and its error mask are all visible after that edge. Each further load moves on the edge where valid and ready are both high. The bench drives and samples on falling edges only. One falling edge after acceptance it checks that no load is yet valid. On the next falling edge it expects the first load or the error mask. From then on it compares one load per handshake, with a backpressure pattern on some packets. Every packet is checked against a greedy grouping computed in the bench from the addresses: directed span boundaries at 255 and 256, single-load and twelve-load packets, descending bases, weight packets, and a few hundred generated packets.

// File: rtl/agl_pkg.sv
package agl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_PLAN,
    ST_ISSUE
  } agl_state_e;
endpackage

// File: rtl/agl_slice_span.sv
module agl_slice_span #(
  parameter int SLICE_ELEMS = 8,
  parameter int ADDR_W      = 20
) (
  input  logic [SLICE_ELEMS-1:0][ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0]                  min_o,
  output logic [ADDR_W-1:0]                  max_o
);
  always_comb begin
    min_o = addr_i[0];
    max_o = addr_i[0];
    for (int k = 1; k < SLICE_ELEMS; k++) begin
      if (addr_i[k] < min_o) min_o = addr_i[k];
      if (addr_i[k] > max_o) max_o = addr_i[k];
    end
  end
endmodule

// File: rtl/agl_group_plan.sv
module agl_group_plan #(
  parameter int NUM_SLICES = 12,
  parameter int ADDR_W     = 20,
  parameter int WIN        = 256,
  parameter int IDX_W      = 4,
  parameter int CNT_W      = 4
) (
  input  logic [NUM_SLICES-1:0][ADDR_W-1:0]     smin_i,
  input  logic [NUM_SLICES-1:0][ADDR_W-1:0]     smax_i,
  output logic [NUM_SLICES-1:0][IDX_W-1:0]      slice_grp_o,
  output logic [NUM_SLICES-1:0][ADDR_W-1:0]     grp_base_o,
  output logic [NUM_SLICES-1:0][NUM_SLICES-1:0] grp_mask_o,
  output logic [CNT_W-1:0]                      n_grp_o,
  output logic [NUM_SLICES-1:0]                 err_o
);
  localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(WIN);

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_err
    assign err_o[s] = (smax_i[s] - smin_i[s]) >= WIN_A;
  end

  logic [ADDR_W-1:0] run_min, run_max, c_min, c_max;
  logic [IDX_W-1:0]  cur;

  // greedy scan in slice order; a group closes when its span would reach WIN
  always_comb begin
    slice_grp_o = '0;
    grp_base_o  = '0;
    grp_mask_o  = '0;
    cur         = '0;
    run_min     = smin_i[0];
    run_max     = smax_i[0];
    c_min       = '0;
    c_max       = '0;
    grp_base_o[0]    = smin_i[0];
    grp_mask_o[0][0] = 1'b1;
    for (int s = 1; s < NUM_SLICES; s++) begin
      c_min = (smin_i[s] < run_min) ? smin_i[s] : run_min;
      c_max = (smax_i[s] > run_max) ? smax_i[s] : run_max;
      if ((c_max - c_min) >= WIN_A) begin
        cur     = cur + 1'b1;
        run_min = smin_i[s];
        run_max = smax_i[s];
      end else begin
        run_min = c_min;
        run_max = c_max;
      end
      grp_base_o[cur]    = run_min;
      grp_mask_o[cur][s] = 1'b1;
      slice_grp_o[s]     = cur;
    end
    n_grp_o = CNT_W'(cur) + CNT_W'(1);
  end
endmodule

// File: rtl/agl_offset_calc.sv
module agl_offset_calc #(
  parameter int NUM_ELEM    = 96,
  parameter int SLICE_ELEMS = 8,
  parameter int NUM_SLICES  = 12,
  parameter int ADDR_W      = 20,
  parameter int IDX_W       = 4,
  parameter int OFF_W       = 8
) (
  input  logic                                weight_i,
  input  logic [NUM_ELEM-1:0][ADDR_W-1:0]     addr_i,
  input  logic [NUM_SLICES-1:0][IDX_W-1:0]    slice_grp_i,
  input  logic [NUM_SLICES-1:0][ADDR_W-1:0]   grp_base_i,
  output logic [NUM_ELEM-1:0][OFF_W-1:0]      off_o,
  output logic [NUM_ELEM-1:0][IDX_W-1:0]      eld_o
);
  for (genvar e = 0; e < NUM_ELEM; e++) begin : g_elem
    localparam int S = e / SLICE_ELEMS;
    assign eld_o[e] = weight_i ? '0 : slice_grp_i[S];
    assign off_o[e] = weight_i ? OFF_W'(e)
                               : OFF_W'(addr_i[e] - grp_base_i[slice_grp_i[S]]);
  end
endmodule

// File: rtl/agl_gather_ldgen.sv
module agl_gather_ldgen
  import agl_pkg::*;
#(
  parameter int NUM_ELEM    = 96,
  parameter int SLICE_ELEMS = 8,
  parameter int ADDR_W      = 20,
  parameter int WIN         = 256,
  localparam int NUM_SLICES = NUM_ELEM / SLICE_ELEMS,
  localparam int IDX_W      = (NUM_SLICES > 1) ? $clog2(NUM_SLICES) : 1,
  localparam int CNT_W      = $clog2(NUM_SLICES + 1),
  localparam int OFF_W      = $clog2(WIN)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         pkt_valid_i,
  output logic                         pkt_ready_o,
  input  logic                         pkt_weight_i,
  input  logic [NUM_ELEM*ADDR_W-1:0]   pkt_addr_i,
  output logic                         ld_valid_o,
  input  logic                         ld_ready_i,
  output logic [ADDR_W-1:0]            ld_base_o,
  output logic [NUM_SLICES-1:0]        ld_slices_o,
  output logic [IDX_W-1:0]             ld_idx_o,
  output logic                         ld_last_o,
  output logic                         ld_weight_o,
  output logic [NUM_ELEM*OFF_W-1:0]    elem_off_o,
  output logic [NUM_ELEM*IDX_W-1:0]    elem_ld_o,
  output logic [NUM_SLICES-1:0]        err_slices_o
);
  agl_state_e state_q;
  logic [NUM_ELEM-1:0][ADDR_W-1:0]     addr_q;
  logic                                weight_q;
  logic [NUM_SLICES-1:0][ADDR_W-1:0]   grp_base_q;
  logic [NUM_SLICES-1:0][NUM_SLICES-1:0] grp_mask_q;
  logic [CNT_W-1:0]                    n_grp_q;
  logic [IDX_W-1:0]                    idx_q;
  logic [NUM_ELEM-1:0][OFF_W-1:0]      off_q;
  logic [NUM_ELEM-1:0][IDX_W-1:0]      eld_q;
  logic [NUM_SLICES-1:0]               err_q;

  logic [NUM_SLICES-1:0][ADDR_W-1:0]   smin, smax;
  logic [NUM_SLICES-1:0][IDX_W-1:0]    slice_grp;
  logic [NUM_SLICES-1:0][ADDR_W-1:0]   grp_base;
  logic [NUM_SLICES-1:0][NUM_SLICES-1:0] grp_mask;
  logic [CNT_W-1:0]                    n_grp;
  logic [NUM_SLICES-1:0]               err_d;
  logic [NUM_ELEM-1:0][OFF_W-1:0]      off_d;
  logic [NUM_ELEM-1:0][IDX_W-1:0]      eld_d;
  logic                                last;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    agl_slice_span #(
      .SLICE_ELEMS(SLICE_ELEMS),
      .ADDR_W     (ADDR_W)
    ) u_span (
      .addr_i(addr_q[s*SLICE_ELEMS +: SLICE_ELEMS]),
      .min_o (smin[s]),
      .max_o (smax[s])
    );
  end

  agl_group_plan #(
    .NUM_SLICES(NUM_SLICES),
    .ADDR_W    (ADDR_W),
    .WIN       (WIN),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_plan (
    .smin_i     (smin),
    .smax_i     (smax),
    .slice_grp_o(slice_grp),
    .grp_base_o (grp_base),
    .grp_mask_o (grp_mask),
    .n_grp_o    (n_grp),
    .err_o      (err_d)
  );

  agl_offset_calc #(
    .NUM_ELEM   (NUM_ELEM),
    .SLICE_ELEMS(SLICE_ELEMS),
    .NUM_SLICES (NUM_SLICES),
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .OFF_W      (OFF_W)
  ) u_off (
    .weight_i   (weight_q),
    .addr_i     (addr_q),
    .slice_grp_i(slice_grp),
    .grp_base_i (grp_base),
    .off_o      (off_d),
    .eld_o      (eld_d)
  );

  assign last = (CNT_W'(idx_q) + CNT_W'(1)) == n_grp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      addr_q     <= '0;
      weight_q   <= 1'b0;
      grp_base_q <= '0;
      grp_mask_q <= '0;
      n_grp_q    <= '0;
      idx_q      <= '0;
      off_q      <= '0;
      eld_q      <= '0;
      err_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pkt_valid_i) begin
            addr_q   <= pkt_addr_i;
            weight_q <= pkt_weight_i;
            state_q  <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          idx_q <= '0;
          off_q <= off_d;
          eld_q <= eld_d;
          if (weight_q) begin
            grp_base_q    <= '0;
            grp_base_q[0] <= addr_q[0];
            grp_mask_q    <= '0;
            grp_mask_q[0] <= '1;
            n_grp_q       <= CNT_W'(1);
            err_q         <= '0;
            state_q       <= ST_ISSUE;
          end else begin
            grp_base_q <= grp_base;
            grp_mask_q <= grp_mask;
            n_grp_q    <= n_grp;
            err_q      <= err_d;
            state_q    <= (|err_d) ? ST_IDLE : ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (ld_ready_i) begin
            if (last) state_q <= ST_IDLE;
            else      idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign pkt_ready_o  = (state_q == ST_IDLE);
  assign ld_valid_o   = (state_q == ST_ISSUE);
  assign ld_base_o    = grp_base_q[idx_q];
  assign ld_slices_o  = grp_mask_q[idx_q];
  assign ld_idx_o     = idx_q;
  assign ld_last_o    = last;
  assign ld_weight_o  = weight_q;
  assign elem_off_o   = off_q;
  assign elem_ld_o    = eld_q;
  assign err_slices_o = err_q;
endmodule

// File: rtl/agl_gather_ldgen_chk.sv
module agl_gather_ldgen_chk #(
  parameter int ADDR_W     = 20,
  parameter int NUM_SLICES = 12,
  parameter int IDX_W      = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  pkt_valid_i,
  input logic                  pkt_ready_o,
  input logic                  ld_valid_o,
  input logic                  ld_ready_i,
  input logic [ADDR_W-1:0]     ld_base_o,
  input logic [NUM_SLICES-1:0] ld_slices_o,
  input logic [IDX_W-1:0]      ld_idx_o,
  input logic                  ld_last_o,
  input logic                  ld_weight_o,
  input logic [NUM_SLICES-1:0] err_slices_o
);
  // R7
  hold_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o && !ld_ready_i |=> ld_valid_o && $stable(ld_base_o)
      && $stable(ld_slices_o) && $stable(ld_idx_o) && $stable(ld_last_o));

  // R6
  accept_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_i && pkt_ready_o |=> !pkt_ready_o && !ld_valid_o);

  // R6
  busy_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> !pkt_ready_o);

  // R3
  first_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ld_valid_o) |-> ld_idx_o == '0);

  // R3
  idx_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o && ld_ready_i && !ld_last_o |=>
      ld_valid_o && ld_idx_o == IDX_W'($past(ld_idx_o) + 1'b1));

  // R3
  slice_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o |-> ld_slices_o != '0);

  // R1
  err_noload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|err_slices_o) |-> !ld_valid_o);

  // R5
  weight_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_valid_o && ld_weight_o |-> ld_last_o && (&ld_slices_o));
endmodule

bind agl_gather_ldgen agl_gather_ldgen_chk #(
  .ADDR_W    (ADDR_W),
  .NUM_SLICES(NUM_SLICES),
  .IDX_W     (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .pkt_valid_i (pkt_valid_i),
  .pkt_ready_o (pkt_ready_o),
  .ld_valid_o  (ld_valid_o),
  .ld_ready_i  (ld_ready_i),
  .ld_base_o   (ld_base_o),
  .ld_slices_o (ld_slices_o),
  .ld_idx_o    (ld_idx_o),
  .ld_last_o   (ld_last_o),
  .ld_weight_o (ld_weight_o),
  .err_slices_o(err_slices_o)
);

// File: tb/agl_gather_ldgen_tb.sv
`timescale 1ns/1ps
module agl_gather_ldgen_tb;
  localparam int NE = 96;
  localparam int SE = 8;
  localparam int NS = 12;
  localparam int AW = 20;
  localparam int OW = 8;
  localparam int IW = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            pkt_valid, pkt_ready, pkt_weight;
  logic [NE*AW-1:0] pkt_addr;
  logic            ld_valid, ld_ready, ld_last, ld_weight;
  logic [AW-1:0]   ld_base;
  logic [NS-1:0]   ld_slices, err_slices;
  logic [IW-1:0]   ld_idx;
  logic [NE*OW-1:0] elem_off;
  logic [NE*IW-1:0] elem_ld;

  agl_gather_ldgen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .pkt_valid_i(pkt_valid), .pkt_ready_o(pkt_ready),
    .pkt_weight_i(pkt_weight), .pkt_addr_i(pkt_addr),
    .ld_valid_o(ld_valid), .ld_ready_i(ld_ready),
    .ld_base_o(ld_base), .ld_slices_o(ld_slices), .ld_idx_o(ld_idx),
    .ld_last_o(ld_last), .ld_weight_o(ld_weight),
    .elem_off_o(elem_off), .elem_ld_o(elem_ld), .err_slices_o(err_slices)
  );

  int checks = 0;
  int fails  = 0;
  int unsigned seed = 32'h1234_5678;

  int a[NE];
  bit wgt;
  bit bp;
  int bp_cnt = 0;
  int e_n;
  int e_base[NS];
  int e_mask[NS];
  int e_off[NE];
  int e_idx[NE];
  int e_err;
  int got_base[NS];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  // greedy reference from the requirements
  task automatic build_ref();
    int smin[NS];
    int smax[NS];
    int rmin, rmax, cmin, cmax, g;
    int grp[NS];
    e_err = 0;
    for (int s = 0; s < NS; s++) begin
      smin[s] = a[s*SE];
      smax[s] = a[s*SE];
      for (int k = 1; k < SE; k++) begin
        if (a[s*SE+k] < smin[s]) smin[s] = a[s*SE+k];
        if (a[s*SE+k] > smax[s]) smax[s] = a[s*SE+k];
      end
      if (smax[s] - smin[s] >= 256) e_err |= (1 << s);
    end
    for (int s = 0; s < NS; s++) begin e_base[s] = 0; e_mask[s] = 0; end
    if (wgt) begin
      e_err = 0;
      e_n = 1;
      e_base[0] = a[0];
      e_mask[0] = (1 << NS) - 1;
      for (int i = 0; i < NE; i++) begin e_off[i] = i; e_idx[i] = 0; end
      return;
    end
    g = 0; rmin = smin[0]; rmax = smax[0];
    e_base[0] = rmin; e_mask[0] = 1; grp[0] = 0;
    for (int s = 1; s < NS; s++) begin
      cmin = (smin[s] < rmin) ? smin[s] : rmin;
      cmax = (smax[s] > rmax) ? smax[s] : rmax;
      if (cmax - cmin >= 256) begin
        g++; rmin = smin[s]; rmax = smax[s];
      end else begin
        rmin = cmin; rmax = cmax;
      end
      e_base[g] = rmin;
      e_mask[g] |= (1 << s);
      grp[s] = g;
    end
    e_n = g + 1;
    for (int i = 0; i < NE; i++) begin
      e_idx[i] = grp[i/SE];
      e_off[i] = a[i] - e_base[grp[i/SE]];
    end
  endtask

  // called at a falling edge with the block idle
  task automatic run_pkt(input string name);
    int k;
    int guard;
    bit rdy, done, prev_rdy;
    int prev_base;
    int bad, bad_i, act_v, exp_v;
    build_ref();
    chk(pkt_ready == 1'b1, "R6", {name, " ready before send"}, pkt_ready, 1);
    for (int i = 0; i < NE; i++) pkt_addr[i*AW +: AW] = AW'(a[i]);
    pkt_weight = wgt;
    pkt_valid  = 1'b1;
    @(posedge clk);
    @(negedge clk);
    pkt_valid = 1'b0;
    chk(!ld_valid && !pkt_ready, "R6", {name, " plan cycle idle outputs"},
        {ld_valid, pkt_ready}, 0);
    @(negedge clk);
    if (e_err != 0) begin
      chk(err_slices == NS'(e_err), "R1", {name, " error mask"}, err_slices, e_err);
      chk(!ld_valid && pkt_ready, "R1", {name, " no load after error"},
          {ld_valid, pkt_ready}, 1);
      @(negedge clk);
      chk(!ld_valid, "R1", {name, " still no load"}, ld_valid, 0);
      return;
    end
    chk(ld_valid == 1'b1, "R6", {name, " first load latency"}, ld_valid, 1);
    chk(err_slices == '0, "R1", {name, " no error mask"}, err_slices, 0);
    k = 0; guard = 0; done = 0; prev_rdy = 1; prev_base = 0;
    while (!done && guard < 200) begin
      if (!ld_valid) begin
        chk(0, "R2", {name, " load missing"}, k, e_n);
        break;
      end
      if (!prev_rdy)
        chk(int'(ld_base) == prev_base, "R7", {name, " held base"}, ld_base, prev_base);
      chk(!pkt_ready, "R6", {name, " busy ready"}, pkt_ready, 0);
      if (k < NS) begin
        chk(int'(ld_base) == e_base[k], "R3", {name, " load base"}, ld_base, e_base[k]);
        chk(int'(ld_slices) == e_mask[k] && int'(ld_idx) == k
            && ld_last == (k == e_n-1) && ld_weight == wgt,
            wgt ? "R5" : "R3", {name, " load fields"},
            {ld_slices, ld_idx, ld_last}, {e_mask[k][NS-1:0], k[IW-1:0], (k == e_n-1)});
        got_base[k] = int'(ld_base);
      end
      prev_base = int'(ld_base);
      rdy = bp ? ((bp_cnt % 3) != 1) : 1'b1;
      bp_cnt++;
      ld_ready = rdy;
      prev_rdy = rdy;
      if (rdy) begin
        if (ld_last) done = 1;
        k++;
      end
      @(negedge clk);
      guard++;
    end
    ld_ready = 1'b0;
    chk(k == e_n, "R2", {name, " load count"}, k, e_n);
    chk(!ld_valid && pkt_ready, "R6", {name, " idle after last"}, {ld_valid, pkt_ready}, 1);
    bad = 0; bad_i = 0; act_v = 0; exp_v = 0;
    for (int i = 0; i < NE; i++) begin
      int o, x;
      o = int'(elem_off[i*OW +: OW]);
      x = int'(elem_ld[i*IW +: IW]);
      if ((o != e_off[i] || x != e_idx[i]) && bad == 0) begin
        bad_i = i; act_v = o; exp_v = e_off[i];
      end
      if (o != e_off[i] || x != e_idx[i]) bad++;
      if (!wgt && x < e_n && (a[i] < got_base[x] || a[i] - got_base[x] > 255)) bad++;
    end
    chk(bad == 0, wgt ? "R5" : "R4", $sformatf("%s table elem %0d", name, bad_i), act_v, exp_v);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pkt_valid = 1'b0; pkt_weight = 1'b0; pkt_addr = '0; ld_ready = 1'b0;
    wgt = 0; bp = 0;
    repeat (3) @(negedge clk);
    chk(pkt_ready && !ld_valid && err_slices == '0, "R8", "reset outputs",
        {pkt_ready, ld_valid}, 2);
    rst_n = 1'b1;
    @(negedge clk);
    chk(pkt_ready && !ld_valid && err_slices == '0, "R8", "after release",
        {pkt_ready, ld_valid}, 2);

    for (int i = 0; i < NE; i++) a[i] = 5000;
    run_pkt("R2 same address");
    for (int i = 0; i < NE; i++) a[i] = 10000 + i;
    run_pkt("R4 contiguous");
    for (int i = 0; i < NE; i++) a[i] = 20000 + 4*i;
    bp = 1;
    run_pkt("R2 stride4");
    for (int i = 0; i < NE; i++) a[i] = 30000 + (i/SE)*300 + (i%SE);
    run_pkt("R2 twelve loads");
    bp = 0;
    for (int i = 0; i < NE; i++) a[i] = 50000 + (i%SE)*10;
    a[47] = 50255;
    run_pkt("R1 span 255 legal");
    for (int i = 0; i < NE; i++) a[i] = 60000;
    for (int i = 48; i < 56; i++) a[i] = 60256;
    run_pkt("R2 group break at 256");
    for (int i = 0; i < NE; i++) a[i] = 60000;
    for (int i = 48; i < 56; i++) a[i] = 60255;
    run_pkt("R2 group hold at 255");
    for (int i = 0; i < NE; i++) a[i] = 70000 + (i%SE);
    a[47] = 70000 + 256;
    run_pkt("R1 span 256 error");
    for (int i = 0; i < NE; i++) a[i] = 90000 - (i/SE)*120 + (i%SE)*3;
    bp = 1;
    run_pkt("R3 descending bases");
    wgt = 1;
    for (int i = 0; i < NE; i++) a[i] = int'(rnd() % 900000);
    a[0] = 80000;
    run_pkt("R5 weight");
    wgt = 0;

    for (int p = 0; p < 300; p++) begin
      int cb, sb, jit, m;
      wgt = (rnd() % 10) == 0;
      bp  = (rnd() % 2) == 0;
      cb = 4096 + int'(rnd() % 200000);
      for (int s = 0; s < NS; s++) begin
        m = int'(rnd() % 4);
        case (m)
          0: sb = cb + int'(rnd() % 64);
          1: sb = cb + 200 + int'(rnd() % 600);
          2: sb = cb - int'(rnd() % 300);
          default: sb = cb;
        endcase
        case (rnd() % 4)
          0: jit = 1;
          1: jit = 16;
          2: jit = 128;
          default: jit = 256;
        endcase
        for (int k = 0; k < SE; k++) a[s*SE+k] = sb + int'(rnd() % jit);
        cb = sb;
      end
      if ((rnd() % 8) == 0) begin
        m = int'(rnd() % NS);
        a[m*SE+3] = a[m*SE] + 256 + int'(rnd() % 100);
      end
      run_pkt($sformatf("R2 generated %0d", p));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule